// File: doc/BRIEF.md
# Cell Voltage and Discharge Current Fault Detector

This block watches a stream of 14-bit cell-voltage codes and two discharge-current comparator lines. It raises a one-cycle fault-set pulse toward a status register when a condition has persisted long enough. It covers four conditions: cell overvoltage, cell undervoltage, overcurrent in discharge and short circuit in discharge.

The voltage limits come from two 8-bit trip registers. Each register is widened to a 14-bit compare level by placing it between fixed preset bits, and the preset bits differ between the overvoltage and undervoltage levels.

Voltage checks run only while the converter-enable input is high. A test input lets voltage faults register on the first offending sample. The two current comparators are sampled on a slow internal tick, one every `TICK_DIV` clocks, and are always active.

The cell stream is a valid/ready interface whose ready is always high. There is no back-pressure, so every cycle with `cell_valid` high is one sample. The upstream converter never has to hold a code.

Top module: `cell_fault_monitor`

## Requirements
- R1: The overvoltage level is the 14-bit value {2'b10, ov_trip[7:0], 4'b1000}; a sample counts as over only when cell_code is strictly greater than it (ov_trip 0xAC gives 10952, so 10952 is not over and 10953 is).
- R2: The undervoltage level is {2'b01, uv_trip[7:0], 4'b0000}; a sample counts as under only when cell_code is strictly less than it (uv_trip 0x97 gives 6512, so 6511 is under and 6512 is not).
- R3: A voltage fault pulse is raised on the sample where the run of consecutive qualifying samples reaches the delay setting (ov_dly or uv_dly, a delay of 0 acting as 1). Any non-qualifying sample resets the run to zero.
- R4: Each fault-set output is a single-cycle pulse. After it fires, it does not fire again until a sample without the condition has been seen and the condition has recurred for the full delay.
- R5: While adc_en is low, ov_set and uv_set stay low and both voltage runs are reset.
- R6: With delay_bypass high, an overvoltage or undervoltage fault fires on the first qualifying sample whatever the delay setting.
- R7: ocd_cmp and scd_cmp are sampled once every TICK_DIV clocks. The matching pulse fires when the run of consecutive high samples reaches ocd_dly or scd_dly (0 acting as 1). These two checks ignore adc_en and delay_bypass.
- R8: After reset, all four fault-set outputs are low and cell_ready is high.
- R9: cell_ready is always high, so every cycle with cell_valid high is taken as one sample.
- R10: In cycles with cell_valid low, cell_code is ignored: the voltage runs do not change and no voltage pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_valid | input | 1 | Cell code sample valid |
| cell_ready | output | 1 | Always high; no back-pressure |
| cell_code | input | 14 | Cell voltage code |
| ov_trip | input | 8 | Overvoltage trip register |
| uv_trip | input | 8 | Undervoltage trip register |
| ov_dly | input | DLY_W | Overvoltage persistence, in samples |
| uv_dly | input | DLY_W | Undervoltage persistence, in samples |
| ocd_dly | input | DLY_W | Overcurrent persistence, in ticks |
| scd_dly | input | DLY_W | Short-circuit persistence, in ticks |
| ocd_cmp | input | 1 | Overcurrent comparator output |
| scd_cmp | input | 1 | Short-circuit comparator output |
| delay_bypass | input | 1 | Test bit: voltage faults skip persistence |
| adc_en | input | 1 | Converter enable; gates voltage checks |
| ov_set | output | 1 | Overvoltage fault-set pulse |
| uv_set | output | 1 | Undervoltage fault-set pulse |
| ocd_set | output | 1 | Overcurrent fault-set pulse |
| scd_set | output | 1 | Short-circuit fault-set pulse |

## Verification
A voltage pulse comes out exactly one clock after the edge that takes the qualifying sample. The bench drives each sample on a falling edge and reads ov_set and uv_set at the next falling edge, comparing them with a reference model of the run counters. Between samples it inserts idle cycles, in which it expects no voltage pulse.

Current pulses follow a tick whose phase the bench does not track. So they are checked by window: no pulse before the earliest possible completion of the delay, then exactly one pulse within the span that must contain it.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam int CODE_W = 14;
  localparam int TRIP_W = 8;
  localparam int NCH    = 4;
  localparam int CH_OV  = 0;
  localparam int CH_UV  = 1;
  localparam int CH_OCD = 2;
  localparam int CH_SCD = 3;

  function automatic logic [CODE_W-1:0] ov_level(input logic [TRIP_W-1:0] trip);
    return {2'b10, trip, 4'b1000};
  endfunction

  function automatic logic [CODE_W-1:0] uv_level(input logic [TRIP_W-1:0] trip);
    return {2'b01, trip, 4'b0000};
  endfunction
endpackage

// File: rtl/cfm_tick_gen.sv
module cfm_tick_gen #(
  parameter int DIV = 6250
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/cfm_level_cmp.sv
module cfm_level_cmp
  import cfm_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic [TRIP_W-1:0] ov_trip,
  input  logic [TRIP_W-1:0] uv_trip,
  output logic              over,
  output logic              under
);
  logic [CODE_W-1:0] ov_lvl, uv_lvl;

  always_comb begin
    ov_lvl = ov_level(ov_trip);
    uv_lvl = uv_level(uv_trip);
    over   = code > ov_lvl;
    under  = code < uv_lvl;
  end
endmodule

// File: rtl/cfm_persist.sv
module cfm_persist #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic             cond,
  input  logic             clear,
  input  logic             bypass,
  input  logic [DLY_W-1:0] limit,
  output logic             fire
);
  logic [DLY_W-1:0] cnt;
  logic             done;
  logic [DLY_W:0]   nxt;

  assign nxt = {1'b0, cnt} + (DLY_W+1)'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (clear) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (sample) begin
        if (!cond) begin
          cnt  <= '0;
          done <= 1'b0;
        end else if (!done) begin
          if (bypass || (nxt >= {1'b0, limit})) begin
            fire <= 1'b1;
            done <= 1'b1;
            cnt  <= '0;
          end else begin
            cnt <= nxt[DLY_W-1:0];
          end
        end
      end
    end
  end
endmodule

// File: rtl/cell_fault_monitor.sv
module cell_fault_monitor
  import cfm_pkg::*;
#(
  parameter int DLY_W    = 8,
  parameter int TICK_DIV = 6250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_valid,
  output logic              cell_ready,
  input  logic [CODE_W-1:0] cell_code,
  input  logic [TRIP_W-1:0] ov_trip,
  input  logic [TRIP_W-1:0] uv_trip,
  input  logic [DLY_W-1:0]  ov_dly,
  input  logic [DLY_W-1:0]  uv_dly,
  input  logic [DLY_W-1:0]  ocd_dly,
  input  logic [DLY_W-1:0]  scd_dly,
  input  logic              ocd_cmp,
  input  logic              scd_cmp,
  input  logic              delay_bypass,
  input  logic              adc_en,
  output logic              ov_set,
  output logic              uv_set,
  output logic              ocd_set,
  output logic              scd_set
);
  logic tick, over, under;
  logic [NCH-1:0]   hit, smp, clr, byp, fire;
  logic [DLY_W-1:0] lim [NCH];

  assign cell_ready = 1'b1;

  cfm_tick_gen #(.DIV(TICK_DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  cfm_level_cmp cmp_i (
    .code(cell_code), .ov_trip(ov_trip), .uv_trip(uv_trip),
    .over(over), .under(under)
  );

  always_comb begin
    hit[CH_OV]  = over;
    hit[CH_UV]  = under;
    hit[CH_OCD] = ocd_cmp;
    hit[CH_SCD] = scd_cmp;
    smp[CH_OV]  = cell_valid;
    smp[CH_UV]  = cell_valid;
    smp[CH_OCD] = tick;
    smp[CH_SCD] = tick;
    clr[CH_OV]  = !adc_en;
    clr[CH_UV]  = !adc_en;
    clr[CH_OCD] = 1'b0;
    clr[CH_SCD] = 1'b0;
    byp[CH_OV]  = delay_bypass;
    byp[CH_UV]  = delay_bypass;
    byp[CH_OCD] = 1'b0;
    byp[CH_SCD] = 1'b0;
    lim[CH_OV]  = ov_dly;
    lim[CH_UV]  = uv_dly;
    lim[CH_OCD] = ocd_dly;
    lim[CH_SCD] = scd_dly;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cfm_persist #(.DLY_W(DLY_W)) persist_i (
      .clk(clk), .rst_n(rst_n), .sample(smp[i]), .cond(hit[i]),
      .clear(clr[i]), .bypass(byp[i]), .limit(lim[i]), .fire(fire[i])
    );
  end

  assign ov_set  = fire[CH_OV];
  assign uv_set  = fire[CH_UV];
  assign ocd_set = fire[CH_OCD];
  assign scd_set = fire[CH_SCD];
endmodule

// File: rtl/cfm_checker.sv
module cfm_checker
  import cfm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cell_valid,
  input logic [CODE_W-1:0] cell_code,
  input logic [TRIP_W-1:0] ov_trip,
  input logic [TRIP_W-1:0] uv_trip,
  input logic              ocd_cmp,
  input logic              scd_cmp,
  input logic              adc_en,
  input logic              ov_set,
  input logic              uv_set,
  input logic              ocd_set,
  input logic              scd_set
);
  // R1
  ov_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_set |-> ($past(cell_valid) && ($past(cell_code) > ov_level($past(ov_trip)))));
  // R2
  uv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_set |-> ($past(cell_valid) && ($past(cell_code) < uv_level($past(uv_trip)))));
  // R1
  ov_uv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ov_set, uv_set}));
  // R4
  ov_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_set |=> !ov_set);
  // R4
  uv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_set |=> !uv_set);
  // R5
  adc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!adc_en) |-> (!ov_set && !uv_set));
  // R7
  ocd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ocd_set |-> $past(ocd_cmp));
  // R7
  scd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scd_set |-> $past(scd_cmp));
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cell_valid) |-> (!ov_set && !uv_set));
endmodule

bind cell_fault_monitor cfm_checker chk_i (
  .clk(clk), .rst_n(rst_n), .cell_valid(cell_valid), .cell_code(cell_code),
  .ov_trip(ov_trip), .uv_trip(uv_trip), .ocd_cmp(ocd_cmp), .scd_cmp(scd_cmp),
  .adc_en(adc_en), .ov_set(ov_set), .uv_set(uv_set), .ocd_set(ocd_set),
  .scd_set(scd_set)
);

// File: tb/cell_fault_monitor_tb_top.sv
`timescale 1ns/1ps
module cell_fault_monitor_tb_top;
  localparam int DLY_W = 8;
  localparam int DIV   = 4;

  logic clk = 0, rst_n = 0;
  logic cell_valid = 0, cell_ready;
  logic [13:0] cell_code = '0;
  logic [7:0] ov_trip = 8'hAC, uv_trip = 8'h97;
  logic [DLY_W-1:0] ov_dly = 0, uv_dly = 0, ocd_dly = 3, scd_dly = 1;
  logic ocd_cmp = 0, scd_cmp = 0, delay_bypass = 0, adc_en = 1;
  logic ov_set, uv_set, ocd_set, scd_set;

  int total = 0, bad = 0;
  bit finished = 0;
  int m_cnt [2];
  bit m_done [2];

  always #2.5 clk = ~clk;

  cell_fault_monitor #(.DLY_W(DLY_W), .TICK_DIV(DIV)) dut_i (.*);

  function automatic int ov_lvl(input logic [7:0] t);
    return 8192 + int'(t) * 16 + 8;
  endfunction
  function automatic int uv_lvl(input logic [7:0] t);
    return 4096 + int'(t) * 16;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model of one voltage run; returns the expected pulse
  function automatic bit model(input int ch, input bit cond, input int lim);
    bit p = 0;
    if (!adc_en || !cond) begin
      m_cnt[ch] = 0; m_done[ch] = 0;
    end else if (!m_done[ch]) begin
      if (delay_bypass || m_cnt[ch] + 1 >= lim) begin
        p = 1; m_done[ch] = 1; m_cnt[ch] = 0;
      end else m_cnt[ch]++;
    end
    return p;
  endfunction

  // drive one sample at a negedge, check at the following negedge
  task automatic send(input int code, input string req);
    bit eo, eu;
    cell_valid = 1; cell_code = 14'(code);
    eo = model(0, code > ov_lvl(ov_trip), int'(ov_dly));
    eu = model(1, code < uv_lvl(uv_trip), int'(uv_dly));
    @(negedge clk);
    cell_valid = 0;
    chk({req, " ov_set"}, ov_set, eo);
    chk({req, " uv_set"}, uv_set, eu);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      cell_code = 14'($urandom_range(0, 16383));
      @(negedge clk);
      chk("R10 idle ov_set", ov_set, 0);
      chk("R10 idle uv_set", uv_set, 0);
    end
  endtask

  task automatic count_cur(input int n, output int no, output int ns);
    no = 0; ns = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      no += ocd_set; ns += scd_set;
    end
  endtask

  initial begin
    int no, ns;
    void'($urandom(32'h5EED_1234));
    m_cnt = '{0, 0}; m_done = '{0, 0};
    repeat (3) @(negedge clk);
    chk("R8 ov_set reset", ov_set, 0);
    chk("R8 ocd_set reset", ocd_set, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R8 cell_ready", cell_ready, 1);
    chk("R9 cell_ready", cell_ready, 1);

    // R1 / R2 boundaries, delay 0 acts as 1
    send(10952, "R1 equal"); idle(1);
    send(10953, "R1 above"); idle(1);
    send(6512, "R2 equal"); idle(1);
    send(6511, "R2 below"); idle(1);
    send(8000, "R4 clear"); idle(1);

    // R3 persistence of 3, broken run
    ov_dly = 3;
    send(12000, "R3 s1"); send(12000, "R3 s2"); send(9000, "R3 break");
    send(12000, "R3 r1"); idle(2); send(12000, "R3 r2"); send(12000, "R3 r3 fire");
    send(12000, "R4 hold"); send(12000, "R4 hold2");
    send(9000, "R4 clear");

    // R6 bypass
    delay_bypass = 1; uv_dly = 5;
    send(100, "R6 bypass uv"); send(100, "R4 after bypass");
    delay_bypass = 0; send(9000, "R6 clear");

    // R5 adc off
    adc_en = 0; ov_dly = 0;
    send(16000, "R5 off ov"); send(50, "R5 off uv");
    adc_en = 1; send(16000, "R5 back on");
    send(9000, "R5 clear");

    // random phase, R3 R4 R5 R6 R10
    for (int it = 0; it < 600; it++) begin
      int sel, code;
      if ($urandom_range(0, 40) == 0) ov_trip = 8'($urandom);
      if ($urandom_range(0, 40) == 0) uv_trip = 8'($urandom);
      if ($urandom_range(0, 20) == 0) ov_dly = DLY_W'($urandom_range(0, 4));
      if ($urandom_range(0, 20) == 0) uv_dly = DLY_W'($urandom_range(0, 4));
      delay_bypass = ($urandom_range(0, 9) == 0);
      adc_en = ($urandom_range(0, 9) != 0);
      sel = $urandom_range(0, 3);
      if (sel == 0) code = ov_lvl(ov_trip) + $urandom_range(0, 4) - 2;
      else if (sel == 1) code = uv_lvl(uv_trip) + $urandom_range(0, 4) - 2;
      else if (sel == 2) code = $urandom_range(0, 16383);
      else code = (ov_lvl(ov_trip) + uv_lvl(uv_trip)) / 2;
      if (code < 0) code = 0;
      if (code > 16383) code = 16383;
      send(code, "R3 random");
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end

    // R7 current faults, comparator ignores adc_en and bypass
    adc_en = 0; delay_bypass = 1; ocd_dly = 3; scd_dly = 1;
    ocd_cmp = 1;
    count_cur(8, no, ns);
    chk("R7 ocd early", no, 0);
    count_cur(8, no, ns);
    chk("R7 ocd fires once", no, 1);
    count_cur(40, no, ns);
    chk("R4 ocd no refire", no, 0);
    ocd_cmp = 0;
    count_cur(10, no, ns);
    chk("R7 ocd low", no, 0);
    ocd_cmp = 1;
    count_cur(16, no, ns);
    chk("R4 ocd recur", no, 1);
    ocd_cmp = 0; count_cur(10, no, ns);
    ocd_cmp = 1;
    count_cur(6, no, ns);
    ocd_cmp = 0;
    count_cur(12, no, ns);
    chk("R7 ocd glitch", no, 0);
    scd_cmp = 1;
    count_cur(6, no, ns);
    chk("R7 scd fires", ns, 1);
    count_cur(20, no, ns);
    chk("R7 scd held", ns, 0);
    scd_cmp = 0;
    adc_en = 1; delay_bypass = 0;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule